// File: doc/BRIEF.md
# SDRAM Power-Up Initialization Sequencer

This block sits on the controller side of an SDRAM interface and owns the command pins from reset until the memory is ready for normal traffic. While reset is held, and for a programmable pause after it, it drives only NOP commands with the clock-enable and all data-mask lines high, so the data bus stays quiet while the device's supplies and clock settle. When the pause expires it issues one precharge of every bank (auto-precharge address bit high). It then waits the precharge recovery time, issues a programmable number of auto-refresh commands spaced by the refresh cycle time, and loads the mode register with a fixed parameter value. After the mode-set recovery time it raises `init_done`, releases the data masks and keeps driving NOP.

The pause length is the clock frequency in kHz times the pause in microseconds, divided by 1000 and rounded up to whole cycles. A non-zero `SIM_PAUSE_CYCLES` replaces it so that short simulations are possible. Each recovery gap (`T_RP`, `T_RC`, `T_MRD`) is given in clocks, and is raised to two when set lower, so that at least one NOP always separates two commands. An asynchronous active-low reset at any time returns the block to the pause.

The states are ST_PAUSE, ST_PRECHARGE, ST_WAIT_RP, ST_REFRESH, ST_WAIT_RC, ST_LOAD_MODE, ST_WAIT_MRD and ST_DONE. The transitions are:
- ST_PAUSE to ST_PRECHARGE when the pause timer expires.
- ST_PRECHARGE to ST_WAIT_RP unconditionally.
- ST_WAIT_RP to ST_REFRESH on timer expiry.
- ST_REFRESH to ST_WAIT_RC unconditionally.
- ST_WAIT_RC to ST_REFRESH on expiry while refreshes remain, or to ST_LOAD_MODE on expiry once all have been sent.
- ST_LOAD_MODE to ST_WAIT_MRD unconditionally.
- ST_WAIT_MRD to ST_DONE on expiry.
- ST_DONE holds.

Top module: `sdram_init_seq`

## Requirements
- R1: While reset is asserted and throughout the pause, the pins carry NOP (cs_n=0, ras_n=1, cas_n=1, we_n=1), cke=1, every dqm bit is 1 and init_done=0; cke stays 1 in every cycle.
- R2: The first non-NOP command appears exactly P cycles after reset is released, where P = SIM_PAUSE_CYCLES if that is non-zero, else ceil(CLK_KHZ*PAUSE_US/1000), and at least 1.
- R3: The first command is precharge-all (cs_n=0, ras_n=0, cas_n=1, we_n=0) with addr bit AP_BIT high, lasting one cycle.
- R4: The first auto-refresh follows the precharge by max(T_RP,2) cycles, with NOP in between.
- R5: Exactly REFRESH_COUNT auto-refresh commands (cs_n=0, ras_n=0, cas_n=0, we_n=1) are issued, each one cycle long, with consecutive ones max(T_RC,2) cycles apart and NOP in between.
- R6: The mode register set (cs_n, ras_n, cas_n and we_n all 0) follows the last refresh by max(T_RC,2) cycles, carries addr=MODE_VALUE and ba=0, and is followed by NOP.
- R7: init_done rises max(T_MRD,2) cycles after the mode register set. dqm drops to 0 in the same cycle. Both then hold, and the pins carry NOP from then on.
- R8: A reset asserted at any point, including mid-sequence or after completion, forces init_done low at once and restarts the whole sequence from the full pause.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cke | output | 1 | Clock enable to the memory |
| cs_n | output | 1 | Chip select, active low |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| ba | output | BA_W | Bank address |
| addr | output | ADDR_W | Address bus (auto-precharge bit, mode value) |
| dqm | output | DQM_W | Data mask lines |
| init_done | output | 1 | High once the sequence has finished |

## Verification
Two decisions meet on the same clock edge at the end of every refresh gap. The timer expires, and the refresh tally decides whether another refresh or the mode register set comes next. An off-by-one in either gives one refresh too many or too few, or a mode set that arrives early. The bench covers this with two configurations, one with eight refreshes and one with two. A reference queue built from the requirements predicts the command in every cycle, and the observed command must match it exactly.

A second collision is a reset that arrives while a refresh gap is being timed. The bench asserts reset in the middle of the refresh train and then expects init_done low together with a full-length pause restarting from the top.

// File: rtl/sdram_init_pkg.sv
package sdram_init_pkg;

    typedef enum logic [2:0] {
        ST_PAUSE,
        ST_PRECHARGE,
        ST_WAIT_RP,
        ST_REFRESH,
        ST_WAIT_RC,
        ST_LOAD_MODE,
        ST_WAIT_MRD,
        ST_DONE
    } init_state_t;

    typedef enum logic [1:0] {
        CMD_NOP,
        CMD_PRECHARGE,
        CMD_REFRESH,
        CMD_MODE_SET
    } sdram_cmd_t;

    // NOP cycles placed between two commands for a recovery time given in clocks
    function automatic int unsigned nop_gap(input int unsigned t_clk);
        return (t_clk < 2) ? 1 : t_clk - 1;
    endfunction

endpackage

// File: rtl/sdram_init_timer.sv
module sdram_init_timer #(
    parameter int unsigned CNT_W     = 8,
    parameter int unsigned RESET_VAL = 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);
    logic [CNT_W-1:0] cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            cnt_q <= CNT_W'(RESET_VAL);
        else if (load)
            cnt_q <= load_val;
        else if (cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    assign expired = (cnt_q == '0);
endmodule

// File: rtl/sdram_init_refcnt.sv
module sdram_init_refcnt #(
    parameter int unsigned TARGET = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic inc,
    output logic reached
);
    localparam int unsigned W = $clog2(TARGET + 1);
    logic [W-1:0] tally_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            tally_q <= '0;
        else if (inc && !reached)
            tally_q <= tally_q + 1'b1;
    end

    assign reached = (tally_q == W'(TARGET));

    // R5: the tally never passes its target
    tally_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        reached |=> reached);
endmodule

// File: rtl/sdram_cmd_drive.sv
module sdram_cmd_drive
    import sdram_init_pkg::*;
(
    input  sdram_cmd_t cmd,
    output logic       cs_n,
    output logic       ras_n,
    output logic       cas_n,
    output logic       we_n
);
    always_comb begin
        cs_n = 1'b0;
        unique case (cmd)
            CMD_NOP:       {ras_n, cas_n, we_n} = 3'b111;
            CMD_PRECHARGE: {ras_n, cas_n, we_n} = 3'b010;
            CMD_REFRESH:   {ras_n, cas_n, we_n} = 3'b001;
            CMD_MODE_SET:  {ras_n, cas_n, we_n} = 3'b000;
            default:       {ras_n, cas_n, we_n} = 3'b111;
        endcase
    end
endmodule

// File: rtl/sdram_init_seq.sv
module sdram_init_seq
    import sdram_init_pkg::*;
#(
    parameter int unsigned CLK_KHZ          = 100000,
    parameter int unsigned PAUSE_US         = 200,
    parameter int unsigned SIM_PAUSE_CYCLES = 0,
    parameter int unsigned REFRESH_COUNT    = 8,
    parameter int unsigned T_RP             = 3,
    parameter int unsigned T_RC             = 7,
    parameter int unsigned T_MRD            = 2,
    parameter int unsigned ADDR_W           = 12,
    parameter int unsigned BA_W             = 2,
    parameter int unsigned DQM_W            = 1,
    parameter int unsigned AP_BIT           = 10,
    parameter logic [ADDR_W-1:0] MODE_VALUE = 12'h032
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic              cke,
    output logic              cs_n,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic [BA_W-1:0]   ba,
    output logic [ADDR_W-1:0] addr,
    output logic [DQM_W-1:0]  dqm,
    output logic              init_done
);
    localparam int unsigned PAUSE_CALC = (CLK_KHZ * PAUSE_US + 999) / 1000;
    localparam int unsigned PAUSE_RAW  = (SIM_PAUSE_CYCLES != 0) ? SIM_PAUSE_CYCLES : PAUSE_CALC;
    localparam int unsigned PAUSE_CYC  = (PAUSE_RAW == 0) ? 1 : PAUSE_RAW;
    localparam int unsigned RP_GAP     = nop_gap(T_RP);
    localparam int unsigned RC_GAP     = nop_gap(T_RC);
    localparam int unsigned MRD_GAP    = nop_gap(T_MRD);
    localparam int unsigned GAP_MAX    = (RP_GAP > RC_GAP) ?
                                         ((RP_GAP > MRD_GAP) ? RP_GAP : MRD_GAP) :
                                         ((RC_GAP > MRD_GAP) ? RC_GAP : MRD_GAP);
    localparam int unsigned CNT_MAX    = (PAUSE_CYC > GAP_MAX) ? PAUSE_CYC : GAP_MAX;
    localparam int unsigned CNT_W      = $clog2(CNT_MAX + 1);

    init_state_t      state_q, state_d;
    sdram_cmd_t       cmd;
    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_expired;
    logic             refs_all;

    sdram_init_timer #(
        .CNT_W     (CNT_W),
        .RESET_VAL (PAUSE_CYC - 1)
    ) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .load_val (tmr_val),
        .expired  (tmr_expired)
    );

    sdram_init_refcnt #(
        .TARGET (REFRESH_COUNT)
    ) u_refcnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .inc     (state_q == ST_REFRESH),
        .reached (refs_all)
    );

    sdram_cmd_drive u_drive (
        .cmd   (cmd),
        .cs_n  (cs_n),
        .ras_n (ras_n),
        .cas_n (cas_n),
        .we_n  (we_n)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            state_q <= ST_PAUSE;
        else
            state_q <= state_d;
    end

    // next state and timer loads
    always_comb begin
        state_d  = state_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        unique case (state_q)
            ST_PAUSE:     if (tmr_expired) state_d = ST_PRECHARGE;
            ST_PRECHARGE: begin
                state_d  = ST_WAIT_RP;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(RP_GAP - 1);
            end
            ST_WAIT_RP:   if (tmr_expired) state_d = ST_REFRESH;
            ST_REFRESH: begin
                state_d  = ST_WAIT_RC;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(RC_GAP - 1);
            end
            ST_WAIT_RC:   if (tmr_expired) state_d = refs_all ? ST_LOAD_MODE : ST_REFRESH;
            ST_LOAD_MODE: begin
                state_d  = ST_WAIT_MRD;
                tmr_load = 1'b1;
                tmr_val  = CNT_W'(MRD_GAP - 1);
            end
            ST_WAIT_MRD:  if (tmr_expired) state_d = ST_DONE;
            ST_DONE:      state_d = ST_DONE;
            default:      state_d = ST_PAUSE;
        endcase
    end

    // outputs
    always_comb begin
        cke       = 1'b1;
        ba        = '0;
        addr      = '0;
        dqm       = '1;
        init_done = 1'b0;
        cmd       = CMD_NOP;
        unique case (state_q)
            ST_PRECHARGE: begin
                cmd          = CMD_PRECHARGE;
                addr[AP_BIT] = 1'b1;
            end
            ST_REFRESH:   cmd = CMD_REFRESH;
            ST_LOAD_MODE: begin
                cmd  = CMD_MODE_SET;
                addr = MODE_VALUE;
            end
            ST_DONE: begin
                dqm       = '0;
                init_done = 1'b1;
            end
            default:      cmd = CMD_NOP;
        endcase
    end

    // R1
    pause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_PAUSE) |-> (ras_n && cas_n && we_n && cke && (&dqm) && !init_done));

    // R3
    precharge_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ras_n && cas_n && !we_n) |-> addr[AP_BIT]);

    // R5
    refresh_count_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ras_n && !cas_n && we_n) |-> !refs_all);

    // R5
    refresh_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && !cas_n && we_n) |=> (ras_n && cas_n && we_n));

    // R6
    mode_after_refs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!cs_n && !ras_n && !cas_n && !we_n) |-> refs_all);

    // R6
    mode_then_nop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!ras_n && !cas_n && !we_n) |=> (ras_n && cas_n && we_n));

    // R7
    done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        init_done |=> (init_done && ras_n && cas_n && we_n && (dqm == '0)));
endmodule

// File: tb/sim_sdram_init_seq.sv
module sim_sdram_init_seq;

    typedef int iq_t[$];

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cke_v, cs_v, ras_v, cas_v, we_v, dqm_v, done_v;
    logic [1:0]  ba_v   [2];
    logic [11:0] addr_v [2];

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    localparam logic [11:0] MODE0 = 12'h032;
    localparam logic [11:0] MODE1 = 12'h5A7;

    always #5 clk = ~clk;

    sdram_init_seq #(
        .SIM_PAUSE_CYCLES (10), .REFRESH_COUNT (8),
        .T_RP (3), .T_RC (4), .T_MRD (3), .MODE_VALUE (MODE0)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .cke (cke_v[0]), .cs_n (cs_v[0]),
        .ras_n (ras_v[0]), .cas_n (cas_v[0]), .we_n (we_v[0]), .ba (ba_v[0]),
        .addr (addr_v[0]), .dqm (dqm_v[0]), .init_done (done_v[0])
    );

    // pause from rounding: ceil(1001*1/1000) = 2; T_RP and T_MRD below two are raised to two
    sdram_init_seq #(
        .CLK_KHZ (1001), .PAUSE_US (1), .SIM_PAUSE_CYCLES (0), .REFRESH_COUNT (2),
        .T_RP (1), .T_RC (3), .T_MRD (1), .MODE_VALUE (MODE1)
    ) u1 (
        .clk (clk), .rst_n (rst_n), .cke (cke_v[1]), .cs_n (cs_v[1]),
        .ras_n (ras_v[1]), .cas_n (cas_v[1]), .we_n (we_v[1]), .ba (ba_v[1]),
        .addr (addr_v[1]), .dqm (dqm_v[1]), .init_done (done_v[1])
    );

    // entry = code + 8*requirement; code 0 NOP, 1 precharge, 2 refresh, 3 mode set, 4 done
    function automatic iq_t build_exp(int p, int trp, int trc, int tmrd, int n);
        iq_t q;
        int grp  = (trp  < 2) ? 2 : trp;
        int grc  = (trc  < 2) ? 2 : trc;
        int gmrd = (tmrd < 2) ? 2 : tmrd;
        for (int i = 0; i < p; i++) q.push_back(0 + 8*2);        // R2 pause
        q.push_back(1 + 8*3);                                      // R3 precharge
        for (int i = 1; i < grp; i++) q.push_back(0 + 8*4);       // R4 gap
        for (int r = 0; r < n; r++) begin
            q.push_back(2 + 8*5);                                  // R5 refresh
            for (int i = 1; i < grc; i++) q.push_back(0 + 8*5);
        end
        q.push_back(3 + 8*6);                                      // R6 mode set
        for (int i = 1; i < gmrd; i++) q.push_back(0 + 8*7);      // R7 recovery
        q.push_back(4 + 8*7);                                      // R7 done
        return q;
    endfunction

    iq_t exp_q [2];

    function automatic int obs_code(int u);
        if (cs_v[u] != 1'b0) return 9;
        case ({ras_v[u], cas_v[u], we_v[u]})
            3'b111:  return done_v[u] ? 4 : 0;
            3'b010:  return 1;
            3'b001:  return 2;
            3'b000:  return 3;
            default: return 9;
        endcase
    endfunction

    task automatic check_cycle(int u, int k, bit r8);
        int e    = (k < exp_q[u].size()) ? exp_q[u][k] : exp_q[u][exp_q[u].size()-1];
        int code = e % 8;
        int req  = e / 8;
        int oc   = obs_code(u);
        logic [1:0] xdqm = (code == 4) ? 2'b00 : 2'b01;
        logic [1:0] odqm = {1'b0, dqm_v[u]};
        checks++;
        if (oc != code || cke_v[u] !== 1'b1 || odqm !== xdqm || done_v[u] !== (code == 4)) begin
            errors++;
            $display("FAIL %sR%0d u%0d cycle %0d: cmd=%0d cke=%b dqm=%b done=%b expected cmd=%0d cke=1 dqm=%b done=%b",
                     r8 ? "R8/" : "", req, u, k, oc, cke_v[u], dqm_v[u], done_v[u], code, xdqm[0], code == 4);
        end
        if (code == 1) begin
            checks++;                                              // R3 auto-precharge bit
            if (addr_v[u][10] !== 1'b1) begin
                errors++;
                $display("FAIL R3 u%0d addr=%h expected bit10=1", u, addr_v[u]);
            end
        end
        if (code == 3) begin
            checks++;                                              // R6 mode value on the bus
            if (addr_v[u] !== (u == 0 ? MODE0 : MODE1) || ba_v[u] !== 2'b00) begin
                errors++;
                $display("FAIL R6 u%0d addr=%h ba=%b expected addr=%h ba=00",
                         u, addr_v[u], ba_v[u], (u == 0 ? MODE0 : MODE1));
            end
        end
    endtask

    task automatic check_reset_state(string tag);
        for (int u = 0; u < 2; u++) begin
            checks++;
            if (obs_code(u) != 0 || cke_v[u] !== 1'b1 || dqm_v[u] !== 1'b1 || done_v[u] !== 1'b0) begin
                errors++;
                $display("FAIL %s u%0d in reset: cmd=%0d cke=%b dqm=%b done=%b expected cmd=0 cke=1 dqm=1 done=0",
                         tag, u, obs_code(u), cke_v[u], dqm_v[u], done_v[u]);
            end
        end
    endtask

    // k counts rising edges since reset release; sampling lies between edges
    task automatic run(int ncyc, bit r8);
        for (int k = 0; k < ncyc; k++) begin
            #1;
            check_cycle(0, k, r8);
            check_cycle(1, k, r8);
            @(negedge clk);
        end
    endtask

    initial begin
        exp_q[0] = build_exp(10, 3, 4, 3, 8);
        exp_q[1] = build_exp(2, 1, 3, 1, 2);
        repeat (3) @(negedge clk);
        #1 check_reset_state("R1");
        @(negedge clk);
        rst_n = 1'b1;
        run(exp_q[0].size() + 6, 1'b0);

        // R8: reset after completion drops init_done at once
        rst_n = 1'b0;
        #1 check_reset_state("R8");
        @(negedge clk);
        rst_n = 1'b1;

        // R8: reset again in the middle of the refresh train
        run(18, 1'b1);
        rst_n = 1'b0;
        #1 check_reset_state("R8");
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        run(exp_q[0].size() + 4, 1'b1);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 5000) begin
            errors = errors + 1;
            checks = checks + 1;
            $display("FAIL watchdog: run exceeded %0d cycles, expected completion", 5000);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule